// File: doc/BRIEF.md
# Fixed-Point Three-Pole Three-Zero Loop Compensator

This block is the digital compensator of a switching power converter control loop. Each time a sample strobe is accepted it takes a 16-bit set-point and a 16-bit measured feedback word. It forms a left-shifted error and evaluates a third-order recursive difference equation. The equation has four feed-forward taps on the error history and three feedback taps on the output history, and all coefficients are signed Q15. The accumulated sum is rounded to 16 bits, multiplied by a post-scale factor, shifted by a signed amount, rounded again and clamped to programmable limits. The result is presented as a duty-cycle word together with a one-cycle completion pulse.

A single multiply-accumulate datapath is time-shared across the seven taps. A small state machine sequences the work: `ST_IDLE` waits for a strobe. `ST_MAC` runs seven multiply-accumulate cycles, in the tap order given in R2. `ST_ROUND` rounds and saturates the accumulator. `ST_SCALE` applies the post-scale multiply, the shift and the second rounding. `ST_CLAMP` limits the value, writes the output, pushes the output history and raises the completion pulse. The transitions are: idle to mac on an accepted strobe; mac to round after the last tap; round to scale to clamp to idle unconditionally; and any state to idle on a clear. The clear input also zeroes both history lines, which is how the loop is initialised before it is closed.

Top module: `iir3p3z_compensator`

## Requirements
- R1: On an accepted strobe the new error is (ref_i − meas_i) taken modulo 2^16, then shifted left by pre_shift_i (0..15) with the bits shifted out discarded. It is stored as e[n], and the three older error samples each move one place down.
- R2: The accumulator starts at zero. It adds 2·C·x for the taps in the order B0·e[n], B1·e[n-1], B2·e[n-2], B3·e[n-3], A1·u[n-1], A2·u[n-2], A3·u[n-3], and each partial sum saturates to the signed 32-bit range. coef_b_i bits [16k+15:16k] hold Bk, and coef_a_i bits [16j+15:16j] hold A(j+1).
- R3: The rounded word is floor((acc + 2^15) / 2^16), saturated to the signed 16-bit range.
- R4: The rounded word y gives p = 2·y·post_scale_i. post_shift_i is a 5-bit two's complement value s. p is shifted arithmetically right by s when s ≥ 0 and left by −s when s < 0. The result z is floor((p + 2^15) / 2^16), saturated to 16 bits.
- R5: duty_o equals lim_min_i if z < lim_min_i, otherwise lim_max_i if z > lim_max_i, otherwise z. All comparisons are signed.
- R6: The clamped output becomes u[n-1] for the next update, and the previous u[n-1] and u[n-2] move one place down.
- R7: duty_o and done_o change on the tenth rising edge after the edge that accepts the strobe. done_o is high for exactly one cycle. busy_o is high from the accepting edge until that tenth edge.
- R8: A strobe that arrives while busy_o is high is ignored: no extra update, no extra done pulse and no history change.
- R9: clear_i zeroes all seven history entries and abandons any update in progress without a done pulse, leaving duty_o unchanged. When clear_i and sample_i are high together, the clear wins.
- R10: Coefficients, post-scale, post-shift, limits, ref_i, meas_i and pre_shift_i are taken at the accepting edge. Changes to them while busy do not affect that update.
- R11: After reset duty_o is 0, done_o and busy_o are low, and both history lines are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sample_i | input | 1 | Sample strobe, starts an update when idle |
| clear_i | input | 1 | Zeroes histories and aborts an update |
| ref_i | input | DW | Set-point word, signed |
| meas_i | input | DW | Measured feedback word, signed |
| pre_shift_i | input | PRW | Left shift applied to the error |
| coef_b_i | input | 4×DW | Feed-forward coefficients B0..B3, Q15 |
| coef_a_i | input | 3×DW | Feedback coefficients A1..A3, Q15 |
| post_scale_i | input | DW | Post-scale multiplier, Q15 |
| post_shift_i | input | PSW | Signed post shift, positive shifts right |
| lim_min_i | input | DW | Lower output limit, signed |
| lim_max_i | input | DW | Upper output limit, signed |
| duty_o | output | DW | Clamped duty-cycle word |
| done_o | output | 1 | One-cycle pulse when duty_o is updated |
| busy_o | output | 1 | High while an update is in progress |

## Verification
The bench builds the block with its defaults: DW = 16, PRW = 4 and PSW = 5. These put pre-shifts that wrap the error word, the extreme post shifts of −16 and +15, and coefficient magnitudes near unity within reach. Such coefficients drive the 32-bit accumulator and both rounding stages into saturation. Because the output history is carried from update to update, chains of updates with nonzero feedback taps check R6 through the arithmetic, and a chain after a clear shows that every history entry was really zeroed.

// File: rtl/comp3p3z_pkg.sv
package comp3p3z_pkg;
    localparam int NUM_B    = 4;
    localparam int NUM_A    = 3;
    localparam int NUM_TAPS = NUM_B + NUM_A;
    localparam int TAP_W    = $clog2(NUM_TAPS);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MAC,
        ST_ROUND,
        ST_SCALE,
        ST_CLAMP
    } comp_state_e;
endpackage

// File: rtl/comp_seq_fsm.sv
module comp_seq_fsm import comp3p3z_pkg::*; (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample_i,
    input  logic             clear_i,
    output logic             start_o,
    output logic             mac_en_o,
    output logic [TAP_W-1:0] tap_o,
    output logic             rnd_en_o,
    output logic             scl_en_o,
    output logic             fin_en_o,
    output logic             busy_o
);
    localparam logic [TAP_W-1:0] TAP_LAST = TAP_W'(NUM_TAPS - 1);

    comp_state_e      state_q, state_d;
    logic [TAP_W-1:0] tap_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // tap counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        tap_q <= '0;
        else if (start_o)  tap_q <= '0;
        else if (mac_en_o) tap_q <= tap_q + TAP_W'(1);
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (clear_i) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:  if (sample_i) state_d = ST_MAC;
                ST_MAC:   if (tap_q == TAP_LAST) state_d = ST_ROUND;
                ST_ROUND: state_d = ST_SCALE;
                ST_SCALE: state_d = ST_CLAMP;
                ST_CLAMP: state_d = ST_IDLE;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        start_o  = 1'b0;
        mac_en_o = 1'b0;
        rnd_en_o = 1'b0;
        scl_en_o = 1'b0;
        fin_en_o = 1'b0;
        busy_o   = (state_q != ST_IDLE);
        tap_o    = tap_q;
        if (!clear_i) begin
            unique case (state_q)
                ST_IDLE:  start_o  = sample_i;
                ST_MAC:   mac_en_o = 1'b1;
                ST_ROUND: rnd_en_o = 1'b1;
                ST_SCALE: scl_en_o = 1'b1;
                ST_CLAMP: fin_en_o = 1'b1;
                default:  ;
            endcase
        end
    end

    // taps advance one per cycle in order
    assert_tap_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MAC && tap_q != TAP_LAST && !clear_i)
        |=> (state_q == ST_MAC && tap_q == $past(tap_q) + TAP_W'(1)));

    // a strobe while computing never restarts the sequence
    assert_busy_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MAC && sample_i && !clear_i) |=> (state_q != ST_IDLE));

    // clear always returns to idle
    assert_clear_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (state_q == ST_IDLE));
endmodule

// File: rtl/comp_coef_bank.sv
module comp_coef_bank import comp3p3z_pkg::*; #(
    parameter int DW  = 16,
    parameter int PSW = 5
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cap_i,
    input  logic [NUM_B-1:0][DW-1:0]     coef_b_i,
    input  logic [NUM_A-1:0][DW-1:0]     coef_a_i,
    input  logic [DW-1:0]                post_scale_i,
    input  logic [PSW-1:0]               post_shift_i,
    input  logic [DW-1:0]                lim_min_i,
    input  logic [DW-1:0]                lim_max_i,
    input  logic [TAP_W-1:0]             tap_i,
    output logic signed [DW-1:0]         coef_o,
    output logic signed [DW-1:0]         post_scale_o,
    output logic [PSW-1:0]               post_shift_o,
    output logic signed [DW-1:0]         lim_min_o,
    output logic signed [DW-1:0]         lim_max_o
);
    logic [NUM_B-1:0][DW-1:0] b_q;
    logic [NUM_A-1:0][DW-1:0] a_q;
    logic [DW-1:0]            ps_q, mn_q, mx_q;
    logic [PSW-1:0]           sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            b_q  <= '0;
            a_q  <= '0;
            ps_q <= '0;
            sh_q <= '0;
            mn_q <= '0;
            mx_q <= '0;
        end else if (cap_i) begin
            b_q  <= coef_b_i;
            a_q  <= coef_a_i;
            ps_q <= post_scale_i;
            sh_q <= post_shift_i;
            mn_q <= lim_min_i;
            mx_q <= lim_max_i;
        end
    end

    always_comb begin
        coef_o = '0;
        for (int i = 0; i < NUM_B; i++)
            if (tap_i == TAP_W'(i)) coef_o = b_q[i];
        for (int j = 0; j < NUM_A; j++)
            if (tap_i == TAP_W'(NUM_B + j)) coef_o = a_q[j];
    end

    assign post_scale_o = ps_q;
    assign post_shift_o = sh_q;
    assign lim_min_o    = mn_q;
    assign lim_max_o    = mx_q;

    // captured set is frozen between strobes
    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_i |=> ($stable(b_q) && $stable(a_q) && $stable(ps_q)
                    && $stable(sh_q) && $stable(mn_q) && $stable(mx_q)));
endmodule

// File: rtl/comp_history.sv
module comp_history import comp3p3z_pkg::*; #(
    parameter int DW  = 16,
    parameter int PRW = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear_i,
    input  logic                 push_err_i,
    input  logic [DW-1:0]        ref_i,
    input  logic [DW-1:0]        meas_i,
    input  logic [PRW-1:0]       pre_shift_i,
    input  logic                 push_ctl_i,
    input  logic [DW-1:0]        ctl_i,
    input  logic [TAP_W-1:0]     tap_i,
    output logic signed [DW-1:0] opnd_o
);
    logic [NUM_B-1:0][DW-1:0] e_q;
    logic [NUM_A-1:0][DW-1:0] u_q;
    logic [DW-1:0]            diff, err;
    logic                     hist_zero;

    assign diff = ref_i - meas_i;
    assign err  = diff << pre_shift_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e_q <= '0;
            u_q <= '0;
        end else if (clear_i) begin
            e_q <= '0;
            u_q <= '0;
        end else begin
            if (push_err_i) begin
                for (int i = NUM_B - 1; i > 0; i--) e_q[i] <= e_q[i-1];
                e_q[0] <= err;
            end
            if (push_ctl_i) begin
                for (int j = NUM_A - 1; j > 0; j--) u_q[j] <= u_q[j-1];
                u_q[0] <= ctl_i;
            end
        end
    end

    always_comb begin
        opnd_o = '0;
        for (int i = 0; i < NUM_B; i++)
            if (tap_i == TAP_W'(i)) opnd_o = e_q[i];
        for (int j = 0; j < NUM_A; j++)
            if (tap_i == TAP_W'(NUM_B + j)) opnd_o = u_q[j];
    end

    assign hist_zero = (e_q == '0) && (u_q == '0);

    assert_clear_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> hist_zero);

    assert_ctl_shift_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (push_ctl_i && !clear_i) |=> (u_q[1] == $past(u_q[0]) && u_q[0] == $past(ctl_i)));

    assert_err_shift_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (push_err_i && !clear_i) |=> (e_q[NUM_B-1] == $past(e_q[NUM_B-2])));
endmodule

// File: rtl/comp_datapath.sv
module comp_datapath #(
    parameter int DW  = 16,
    parameter int PSW = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic                 mac_en_i,
    input  logic                 rnd_en_i,
    input  logic                 scl_en_i,
    input  logic                 fin_en_i,
    input  logic signed [DW-1:0] coef_i,
    input  logic signed [DW-1:0] opnd_i,
    input  logic signed [DW-1:0] post_scale_i,
    input  logic [PSW-1:0]       post_shift_i,
    input  logic signed [DW-1:0] lim_min_i,
    input  logic signed [DW-1:0] lim_max_i,
    output logic signed [DW-1:0] clamp_o,
    output logic signed [DW-1:0] duty_o,
    output logic                 done_o
);
    localparam int ACCW = 2 * DW;
    localparam int XW   = 2 * DW + 2 + (1 << (PSW - 1));
    localparam int ZW   = XW - DW;
    localparam logic signed [DW-1:0]   DMAX  = {1'b0, {(DW-1){1'b1}}};
    localparam logic signed [DW-1:0]   DMIN  = {1'b1, {(DW-1){1'b0}}};
    localparam logic [ACCW+1:0]        RND_A = (ACCW+2)'(1) << (DW - 1);
    localparam logic [XW-1:0]          RND_X = XW'(1) << (DW - 1);

    // multiply-accumulate
    logic signed [ACCW-1:0]  acc_q, acc_sat;
    logic signed [2*DW-1:0]  prod;
    logic        [ACCW+1:0]  sum;

    assign prod = $signed({{DW{coef_i[DW-1]}}, coef_i}) * $signed({{DW{opnd_i[DW-1]}}, opnd_i});
    assign sum  = {{2{acc_q[ACCW-1]}}, acc_q} + {prod[2*DW-1], prod, 1'b0};

    always_comb begin
        if (&sum[ACCW+1:ACCW-1] || ~|sum[ACCW+1:ACCW-1])
            acc_sat = sum[ACCW-1:0];
        else if (sum[ACCW+1])
            acc_sat = {1'b1, {(ACCW-1){1'b0}}};
        else
            acc_sat = {1'b0, {(ACCW-1){1'b1}}};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        acc_q <= '0;
        else if (start_i)  acc_q <= '0;
        else if (mac_en_i) acc_q <= acc_sat;
    end

    // first rounding
    logic [ACCW+1:0]       rsum;
    logic [DW+1:0]         rw;
    logic signed [DW-1:0]  y_d, y_q;

    assign rsum = {{2{acc_q[ACCW-1]}}, acc_q} + RND_A;
    assign rw   = rsum[ACCW+1:DW];

    always_comb begin
        if (&rw[DW+1:DW-1] || ~|rw[DW+1:DW-1]) y_d = rw[DW-1:0];
        else if (rw[DW+1])                      y_d = DMIN;
        else                                    y_d = DMAX;
    end

    // post scale, shift, second rounding
    logic signed [2*DW-1:0] sprod;
    logic signed [XW-1:0]   v, vs;
    logic        [PSW:0]    mag;
    logic        [XW-1:0]   ssum;
    logic        [ZW-1:0]   zw;
    logic signed [DW-1:0]   z_d, z_q;

    assign sprod = $signed({{DW{y_q[DW-1]}}, y_q}) * $signed({{DW{post_scale_i[DW-1]}}, post_scale_i});
    assign v     = {{(XW-2*DW-1){sprod[2*DW-1]}}, sprod, 1'b0};
    assign mag   = -{post_shift_i[PSW-1], post_shift_i};

    always_comb begin
        if (post_shift_i[PSW-1]) vs = v <<< mag;
        else                     vs = v >>> post_shift_i;
    end

    assign ssum = vs + RND_X;
    assign zw   = ssum[XW-1:DW];

    always_comb begin
        if (&zw[ZW-1:DW-1] || ~|zw[ZW-1:DW-1]) z_d = zw[DW-1:0];
        else if (zw[ZW-1])                      z_d = DMIN;
        else                                    z_d = DMAX;
    end

    // clamp
    always_comb begin
        if (z_q < lim_min_i)      clamp_o = lim_min_i;
        else if (z_q > lim_max_i) clamp_o = lim_max_i;
        else                      clamp_o = z_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            y_q    <= '0;
            z_q    <= '0;
            duty_o <= '0;
            done_o <= 1'b0;
        end else begin
            if (rnd_en_i) y_q <= y_d;
            if (scl_en_i) z_q <= z_d;
            if (fin_en_i) duty_o <= clamp_o;
            done_o <= fin_en_i;
        end
    end

    assert_acc_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (acc_q == '0));

    assert_round_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rnd_en_i && acc_q[ACCW-1:DW] != DMAX)
        |=> (y_q == $past(acc_q[ACCW-1:DW]) || y_q == $past(acc_q[ACCW-1:DW]) + DW'(1)));

    assert_clamp_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fin_en_i && lim_min_i <= lim_max_i)
        |=> (duty_o >= $past(lim_min_i) && duty_o <= $past(lim_max_i)));

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
endmodule

// File: rtl/iir3p3z_compensator.sv
module iir3p3z_compensator import comp3p3z_pkg::*; #(
    parameter int DW  = 16,
    parameter int PRW = 4,
    parameter int PSW = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sample_i,
    input  logic                     clear_i,
    input  logic [DW-1:0]            ref_i,
    input  logic [DW-1:0]            meas_i,
    input  logic [PRW-1:0]           pre_shift_i,
    input  logic [NUM_B-1:0][DW-1:0] coef_b_i,
    input  logic [NUM_A-1:0][DW-1:0] coef_a_i,
    input  logic [DW-1:0]            post_scale_i,
    input  logic [PSW-1:0]           post_shift_i,
    input  logic [DW-1:0]            lim_min_i,
    input  logic [DW-1:0]            lim_max_i,
    output logic [DW-1:0]            duty_o,
    output logic                     done_o,
    output logic                     busy_o
);
    logic                 start, mac_en, rnd_en, scl_en, fin_en;
    logic [TAP_W-1:0]     tap;
    logic signed [DW-1:0] coef, opnd, pscale, lmin, lmax, clamp, duty;
    logic [PSW-1:0]       pshift;

    comp_seq_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .sample_i (sample_i),
        .clear_i  (clear_i),
        .start_o  (start),
        .mac_en_o (mac_en),
        .tap_o    (tap),
        .rnd_en_o (rnd_en),
        .scl_en_o (scl_en),
        .fin_en_o (fin_en),
        .busy_o   (busy_o)
    );

    comp_coef_bank #(.DW(DW), .PSW(PSW)) u_bank (
        .clk          (clk),
        .rst_n        (rst_n),
        .cap_i        (start),
        .coef_b_i     (coef_b_i),
        .coef_a_i     (coef_a_i),
        .post_scale_i (post_scale_i),
        .post_shift_i (post_shift_i),
        .lim_min_i    (lim_min_i),
        .lim_max_i    (lim_max_i),
        .tap_i        (tap),
        .coef_o       (coef),
        .post_scale_o (pscale),
        .post_shift_o (pshift),
        .lim_min_o    (lmin),
        .lim_max_o    (lmax)
    );

    comp_history #(.DW(DW), .PRW(PRW)) u_hist (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_i     (clear_i),
        .push_err_i  (start),
        .ref_i       (ref_i),
        .meas_i      (meas_i),
        .pre_shift_i (pre_shift_i),
        .push_ctl_i  (fin_en),
        .ctl_i       (clamp),
        .tap_i       (tap),
        .opnd_o      (opnd)
    );

    comp_datapath #(.DW(DW), .PSW(PSW)) u_dp (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start),
        .mac_en_i     (mac_en),
        .rnd_en_i     (rnd_en),
        .scl_en_i     (scl_en),
        .fin_en_i     (fin_en),
        .coef_i       (coef),
        .opnd_i       (opnd),
        .post_scale_i (pscale),
        .post_shift_i (pshift),
        .lim_min_i    (lmin),
        .lim_max_i    (lmax),
        .clamp_o      (clamp),
        .duty_o       (duty),
        .done_o       (done_o)
    );

    assign duty_o = duty;

    assert_busy_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);
endmodule

// File: tb/iir3p3z_compensator_tb.sv
module iir3p3z_compensator_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sample = 1'b0, clear = 1'b0;
    logic [15:0] ref_w, meas_w, post_scale, lim_min, lim_max, duty;
    logic [3:0]  pre_shift;
    logic [4:0]  post_shift;
    logic [3:0][15:0] coef_b;
    logic [2:0][15:0] coef_a;
    logic        done, busy;

    always #4 clk = ~clk;

    iir3p3z_compensator u_dut (
        .clk(clk), .rst_n(rst_n), .sample_i(sample), .clear_i(clear),
        .ref_i(ref_w), .meas_i(meas_w), .pre_shift_i(pre_shift),
        .coef_b_i(coef_b), .coef_a_i(coef_a), .post_scale_i(post_scale),
        .post_shift_i(post_shift), .lim_min_i(lim_min), .lim_max_i(lim_max),
        .duty_o(duty), .done_o(done), .busy_o(busy)
    );

    int n_chk = 0, n_err = 0;
    int cb[4], ca[3], m_e[4], m_u[3];
    int rf, ms, pre, ps_v, sh_v, mn, mx, last_duty;

    task automatic check(input string req, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic longint satn(input longint v, input int bits);
        longint hi = (longint'(1) << (bits - 1)) - 1;
        longint lo = -hi - 1;
        return (v > hi) ? hi : ((v < lo) ? lo : v);
    endfunction

    function automatic int model_step();
        logic [15:0] d;
        longint acc, y, p, z, c, x;
        int out;
        d = 16'(rf) - 16'(ms);
        d = d << pre;
        for (int i = 3; i > 0; i--) m_e[i] = m_e[i-1];
        m_e[0] = int'($signed(d));
        acc = 0;
        for (int t = 0; t < 7; t++) begin
            c = (t < 4) ? cb[t] : ca[t-4];
            x = (t < 4) ? m_e[t] : m_u[t-4];
            acc = satn(acc + 2 * c * x, 32);
        end
        y = satn((acc + 32768) >>> 16, 16);
        p = 2 * y * longint'(ps_v);
        if (sh_v >= 0) p = p >>> sh_v;
        else           p = p <<< (-sh_v);
        z = satn((p + 32768) >>> 16, 16);
        out = (z < mn) ? mn : ((z > mx) ? mx : int'(z));
        for (int j = 2; j > 0; j--) m_u[j] = m_u[j-1];
        m_u[0] = out;
        return out;
    endfunction

    task automatic apply();
        for (int i = 0; i < 4; i++) coef_b[i] = 16'(cb[i]);
        for (int j = 0; j < 3; j++) coef_a[j] = 16'(ca[j]);
        ref_w = 16'(rf); meas_w = 16'(ms); pre_shift = 4'(pre);
        post_scale = 16'(ps_v); post_shift = 5'(sh_v);
        lim_min = 16'(mn); lim_max = 16'(mx);
    endtask

    // mode 0: plain, 1: strobe while busy, 2: inputs changed while busy
    task automatic run_update(input string req, input int mode);
        int exp, lat, ndone, got;
        exp = model_step();
        @(negedge clk); apply(); sample = 1'b1;
        @(negedge clk); sample = 1'b0;
        if (mode == 0) check("R7", "busy after accept", longint'(busy), 1);
        lat = -1; ndone = 0; got = 0;
        for (int k = 0; k < 16; k++) begin
            if (mode == 1 && k == 3) begin sample = 1'b1; ref_w = 16'sd12345; end
            if (mode == 1 && k == 4) sample = 1'b0;
            if (mode == 2 && k == 2) begin
                coef_b = '0; coef_a = '0; post_scale = 16'h7fff; post_shift = 5'd0;
                lim_min = 16'h8000; lim_max = 16'h7fff; ref_w = 16'd0; meas_w = 16'd0;
            end
            @(negedge clk);
            if (done) begin
                ndone++;
                if (lat < 0) begin
                    lat = k + 1; got = int'($signed(duty));
                    if (mode == 0) check("R7", "busy at done", longint'(busy), 0);
                end
            end
        end
        apply();
        check("R7", "latency", lat, 10);
        check((mode == 1) ? "R8" : "R7", "done count", ndone, 1);
        check(req, "duty", got, exp);
        last_duty = got;
    endtask

    task automatic test_reset();
        check("R11", "duty after reset", longint'(duty), 0);
        check("R11", "done after reset", longint'(done), 0);
        check("R11", "busy after reset", longint'(busy), 0);
    endtask

    task automatic test_basic();
        cb = '{8192, 4096, -2048, 1024}; ca = '{16384, -8192, 4096};
        rf = 1000; ms = 600; pre = 0; ps_v = 32767; sh_v = 0; mn = -32768; mx = 32767;
        run_update("R2", 0);
        rf = 500; ms = 900; run_update("R6", 0);
        rf = -300; ms = 200; run_update("R6", 0);
        rf = 0; ms = 0; run_update("R6", 0);
    endtask

    task automatic test_preshift();
        rf = -200; ms = 100; pre = 3; run_update("R1", 0);
        rf = 1000; ms = 0; pre = 6; run_update("R1", 0);
        pre = 0;
    endtask

    task automatic test_acc_sat();
        cb = '{32767, 32767, 32767, 32767}; ca = '{32767, 32767, 32767};
        rf = 30000; ms = -2000;
        for (int i = 0; i < 3; i++) run_update("R3", 0);
        cb = '{-32768, -32768, -32768, -32768}; run_update("R2", 0);
    endtask

    task automatic test_post_shift();
        cb = '{16384, 0, 0, 0}; ca = '{0, 0, 0}; rf = 2000; ms = 0; ps_v = 20000;
        sh_v = 2;   run_update("R4", 0);
        sh_v = -3;  run_update("R4", 0);
        sh_v = -16; run_update("R4", 0);
        sh_v = 15;  run_update("R4", 0);
        sh_v = 0; ps_v = -32768; run_update("R4", 0);
        ps_v = 32767;
    endtask

    task automatic test_clamp();
        mn = -100; mx = 200;
        rf = 5000;  ms = 0; run_update("R5", 0);
        rf = -5000; run_update("R5", 0);
        rf = 150;   run_update("R5", 0);
        mn = -32768; mx = 32767;
    endtask

    task automatic test_busy_strobe();
        cb = '{8192, 4096, 2048, 1024}; ca = '{8192, 4096, 2048};
        rf = 700; ms = 100; run_update("R8", 1);
        rf = 300; run_update("R8", 0);
    endtask

    task automatic test_capture();
        rf = 900; ms = 50; pre = 1; sh_v = -1; mn = -1000; mx = 1500;
        run_update("R10", 2);
        pre = 0; sh_v = 0; mn = -32768; mx = 32767;
    endtask

    task automatic test_clear_abort();
        int k;
        rf = 1200; ms = 0;
        @(negedge clk); apply(); sample = 1'b1;
        @(negedge clk); sample = 1'b0;
        k = 0;
        repeat (3) @(negedge clk);
        clear = 1'b1;
        @(negedge clk); clear = 1'b0;
        for (int i = 0; i < 14; i++) begin
            @(negedge clk);
            if (done) k++;
        end
        check("R9", "no done after abort", k, 0);
        check("R9", "duty kept after abort", int'($signed(duty)), last_duty);
        check("R9", "busy after abort", longint'(busy), 0);
        for (int i = 0; i < 4; i++) m_e[i] = 0;
        for (int j = 0; j < 3; j++) m_u[j] = 0;
        rf = 400; ms = 100; run_update("R9", 0);
        rf = 100; run_update("R9", 0);
    endtask

    task automatic test_clear_vs_sample();
        @(negedge clk); sample = 1'b1; clear = 1'b1;
        @(negedge clk); sample = 1'b0; clear = 1'b0;
        check("R9", "clear beats strobe", longint'(busy), 0);
        for (int i = 0; i < 4; i++) m_e[i] = 0;
        for (int j = 0; j < 3; j++) m_u[j] = 0;
        rf = 800; ms = 300; run_update("R9", 0);
    endtask

    initial begin
        cb = '{0, 0, 0, 0}; ca = '{0, 0, 0}; m_e = '{0, 0, 0, 0}; m_u = '{0, 0, 0};
        rf = 0; ms = 0; pre = 0; ps_v = 32767; sh_v = 0; mn = -32768; mx = 32767;
        last_duty = 0;
        apply();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_basic();
        test_preshift();
        test_acc_sat();
        test_post_shift();
        test_clamp();
        test_busy_strobe();
        test_capture();
        test_clear_abort();
        test_clear_vs_sample();
        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule